// File: doc/BRIEF.md
# Serial Byte-Register Access Slave with Burst Addressing

This block lets an external host read and write a bank of 128 byte-wide registers over a four-wire serial link. The link runs in clock-polarity-0, clock-phase-0 form. All link signals are synchronised into the system clock and their edges are detected there, so the whole block sits in a single clock domain.

Each transaction opens with a command byte. Its top bit picks write or read, and the remaining seven bits give the starting address. Data bytes follow for as long as select stays low. After every data byte the address moves up by one, except at the receive-queue address. That address stays put, so successive bytes drain successive queue entries.

Two addresses have side effects:
- **Event status register.** Event pulses set its bits. Reading it clears exactly the bits that were returned to the host. The active-low interrupt line is low while any status bit that is also set in the enable register is set.
- **Receive-queue address.** It pops the internal first-in first-out queue, which is loaded from a local push port.

Top module: `spi_regfile_slave`

## Requirements
- R1: A command byte is sent MSB first on the rising clock edge. Bit 7 = 1 selects a write and bit 7 = 0 selects a read. Bits 6..0 are the starting address.
- R2: On a read, the addressed byte leaves MSB first. It appears on the next eight falling clock edges after the command byte. The data bits the host sends during a read are discarded and change no register.
- R3: While select stays low, each further data byte moves the address up by one (modulo 128) for both writes and reads, and each write byte is stored at the current address.
- R4: Address 0x7F is the receive-queue port and never advances within a burst. Each data byte read there returns and removes the oldest entry. An empty queue returns 0x00 and removes nothing. An entry is removed only once the host clocks the first bit of the byte that carries it. Writes to 0x7F are discarded.
- R5: Address 0x03 holds the event status. A one-cycle pulse on evt_in bit i sets bit i. Host writes to 0x03 are discarded. A read of 0x03 clears exactly the bits it returned.
- R6: irq_n is low while (status AND enable register at 0x04) is nonzero. It stays low until a status read clears those bits, and then it returns high.
- R7: An event that arrives in the same cycle as the clearing read of its bit leaves that bit set.
- R8: spi_miso_en is high only while spi_cs_n is low. While select is high, spi_miso rests at 0.
- R9: Raising select before the eighth bit of a byte discards that partial byte without any register write. The next transaction starts cleanly with a command byte.
- R10: After reset, every register reads 0x00, the queue is empty and irq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_en | output | 1 | Output-driver enable for spi_miso (pad is released when low) |
| irq_n | output | 1 | Active-low interrupt request |
| evt_in | input | STAT_W (8) | One-cycle event pulses that set status bits |
| fifo_wr_en | input | 1 | Push strobe for the receive queue |
| fifo_wr_data | input | 8 | Byte pushed into the receive queue |

## Verification
Several internal faults show up on the very next serial byte:
- A bad bit counter or address register returns bytes from the wrong address, or bytes shifted by one bit position.
- A stale address step makes a burst read return a repeated or skipped value.

Queue and status faults surface more slowly. A queue entry removed too early, or a status bit cleared without being returned, is only visible in the following transaction: the host sees a missing queue byte, or a status read of 0x00 where an event should have survived. A wrong interrupt-enable combination shows on irq_n within one system clock of the event or of the clearing byte.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [ADDR_W-1:0] addr_t;

   // Next burst address: the queue port stays fixed, everything else wraps upward.
   function automatic addr_t burst_next(input addr_t cur, input addr_t hold_addr);
      return (cur == hold_addr) ? cur : addr_t'(cur + 1'b1);
   endfunction

endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
   parameter int           N       = 3,
   parameter int           STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] dout
);

   initial begin
      assert (STAGES >= 1 && STAGES <= 4) else $error("spi_rf_sync: STAGES out of range");
   end

   for (genvar b = 0; b < N; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RST_VAL[b];
            else        chain <= din[b];
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], din[b]};
         end
      end
      assign dout[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
   import spi_rf_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sck_s,
   input  logic  cs_n_s,
   input  logic  mosi_s,
   output logic  cs_act,
   output logic  sck_fall,
   output logic  byte_vld,
   output logic  byte_cmd,
   output byte_t byte_val,
   output logic  data_bit0
);

   localparam int CNT_W = $clog2(BYTE_W);

   logic              sck_d;
   logic              sck_rise;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] rx_sh;
   logic              first_q;

   assign cs_act    = ~cs_n_s;
   assign sck_rise  = cs_act &  sck_s & ~sck_d;
   assign sck_fall  = cs_act & ~sck_s &  sck_d;
   assign byte_vld  = sck_rise & (bit_cnt == CNT_W'(BYTE_W - 1));
   assign byte_cmd  = first_q;
   assign byte_val  = {rx_sh, mosi_s};
   assign data_bit0 = sck_rise & (bit_cnt == '0) & ~first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d   <= 1'b0;
         bit_cnt <= '0;
         rx_sh   <= '0;
         first_q <= 1'b1;
      end else begin
         sck_d <= sck_s;
         if (!cs_act) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            first_q <= 1'b1;
         end else if (sck_rise) begin
            rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_s};
            bit_cnt <= CNT_W'(bit_cnt + 1'b1);
            if (bit_cnt == CNT_W'(BYTE_W - 1)) first_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/spi_rf_fifo.sv
module spi_rf_fifo
   import spi_rf_pkg::*;
#(
   parameter int DEPTH = 64
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  push,
   input  byte_t din,
   input  logic  pop,
   output byte_t head,
   output logic  empty
);

   localparam int PTR_W = $clog2(DEPTH);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("spi_rf_fifo: DEPTH must be a power of two");
   end

   byte_t          store [DEPTH];
   logic [PTR_W:0] wr_ptr;
   logic [PTR_W:0] rd_ptr;
   logic           full;

   assign empty = (wr_ptr == rd_ptr);
   assign full  = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) &&
                  (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]);
   assign head  = store[rd_ptr[PTR_W-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         for (int k = 0; k < DEPTH; k++) store[k] <= '0;
      end else begin
         if (push && !full) begin
            store[wr_ptr[PTR_W-1:0]] <= din;
            wr_ptr <= wr_ptr + 1'b1;
         end
         if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
      end
   end

endmodule

// File: rtl/spi_rf_status.sv
module spi_rf_status #(
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] evt,
   input  logic [STAT_W-1:0] clr_mask,
   input  logic [STAT_W-1:0] en_mask,
   output logic [STAT_W-1:0] stat,
   output logic              irq_n
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~clr_mask) | evt;
   end

   assign irq_n = ~|(stat & en_mask);

endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
   import spi_rf_pkg::*;
#(
   parameter int          STAT_W      = 8,
   parameter int          FIFO_DEPTH  = 64,
   parameter int          SYNC_STAGES = 2,
   parameter logic [6:0]  STAT_ADDR   = 7'h03,
   parameter logic [6:0]  MASK_ADDR   = 7'h04,
   parameter logic [6:0]  FIFO_ADDR   = 7'h7F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_en,
   output logic              irq_n,
   input  logic [STAT_W-1:0] evt_in,
   input  logic              fifo_wr_en,
   input  logic [7:0]        fifo_wr_data
);

   localparam int REGS = 1 << ADDR_W;

   initial begin
      assert (STAT_W >= 1 && STAT_W <= BYTE_W) else $error("STAT_W must fit in one byte");
      assert (STAT_ADDR != MASK_ADDR && STAT_ADDR != FIFO_ADDR && MASK_ADDR != FIFO_ADDR)
         else $error("special addresses must differ");
   end

   // ---------------- synchronisers ----------------
   logic sck_s, cs_n_s, mosi_s;

   spi_rf_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_sck, spi_cs_n, spi_mosi}),
      .dout ({sck_s, cs_n_s, mosi_s})
   );

   // ---------------- byte framing ----------------
   logic  cs_act, sck_fall, byte_vld, byte_cmd, data_bit0;
   byte_t byte_val;

   spi_rf_frame u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_s    (sck_s),
      .cs_n_s   (cs_n_s),
      .mosi_s   (mosi_s),
      .cs_act   (cs_act),
      .sck_fall (sck_fall),
      .byte_vld (byte_vld),
      .byte_cmd (byte_cmd),
      .byte_val (byte_val),
      .data_bit0(data_bit0)
   );

   // ---------------- storage and side blocks ----------------
   byte_t             regs [REGS];
   byte_t             fifo_head;
   logic              fifo_empty;
   logic              pop;
   logic [STAT_W-1:0] stat_q;
   logic [STAT_W-1:0] clr_mask;
   logic [STAT_W-1:0] en_mask;

   spi_rf_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .push (fifo_wr_en),
      .din  (fifo_wr_data),
      .pop  (pop),
      .head (fifo_head),
      .empty(fifo_empty)
   );

   assign en_mask = regs[MASK_ADDR][STAT_W-1:0];

   spi_rf_status #(.STAT_W(STAT_W)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_in),
      .clr_mask(clr_mask),
      .en_mask (en_mask),
      .stat    (stat_q),
      .irq_n   (irq_n)
   );

   // ---------------- transaction control ----------------
   addr_t             addr_q;
   logic              wr_q;
   byte_t             tx_sh;
   logic              miso_q;
   logic              pend_q;
   logic              pend_stat_q;
   logic              pend_pop_q;
   logic [STAT_W-1:0] pend_cap_q;

   addr_t ld_addr;
   byte_t ld_val;
   byte_t stat_byte;
   logic  do_load;
   logic  wr_en;
   logic  commit;

   always_comb begin
      stat_byte                = '0;
      stat_byte[STAT_W-1:0]    = stat_q;
   end

   assign ld_addr = byte_cmd ? byte_val[ADDR_W-1:0] : burst_next(addr_q, FIFO_ADDR);

   always_comb begin
      if (ld_addr == STAT_ADDR)      ld_val = stat_byte;
      else if (ld_addr == FIFO_ADDR) ld_val = fifo_empty ? '0 : fifo_head;
      else                           ld_val = regs[ld_addr];
   end

   assign do_load  = byte_vld & (byte_cmd ? ~byte_val[BYTE_W-1] : ~wr_q);
   assign wr_en    = byte_vld & ~byte_cmd & wr_q &
                     (addr_q != STAT_ADDR) & (addr_q != FIFO_ADDR);
   assign commit   = data_bit0 & pend_q;
   assign clr_mask = (commit && pend_stat_q) ? pend_cap_q : '0;
   assign pop      = commit & pend_pop_q;

   // address and direction
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         wr_q   <= 1'b0;
      end else if (byte_vld) begin
         if (byte_cmd) begin
            addr_q <= byte_val[ADDR_W-1:0];
            wr_q   <= byte_val[BYTE_W-1];
         end else begin
            addr_q <= burst_next(addr_q, FIFO_ADDR);
         end
      end
   end

   // register file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < REGS; k++) regs[k] <= '0;
      end else if (wr_en) begin
         regs[addr_q] <= byte_val;
      end
   end

   // outgoing shifter, changes on falling serial edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh  <= '0;
         miso_q <= 1'b0;
      end else if (!cs_act) begin
         tx_sh  <= '0;
         miso_q <= 1'b0;
      end else if (do_load) begin
         tx_sh <= ld_val;
      end else if (sck_fall) begin
         miso_q <= tx_sh[BYTE_W-1];
         tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
   end

   // deferred read side effects: applied when the host clocks the byte's first bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_stat_q <= 1'b0;
         pend_pop_q  <= 1'b0;
         pend_cap_q  <= '0;
      end else if (!cs_act) begin
         pend_q <= 1'b0;
      end else if (do_load) begin
         pend_q      <= 1'b1;
         pend_stat_q <= (ld_addr == STAT_ADDR);
         pend_pop_q  <= (ld_addr == FIFO_ADDR) & ~fifo_empty;
         pend_cap_q  <= stat_q;
      end else if (commit) begin
         pend_q <= 1'b0;
      end
   end

   assign spi_miso    = miso_q;
   assign spi_miso_en = ~spi_cs_n;

endmodule

// File: rtl/spi_rf_checker.sv
module spi_rf_checker #(
   parameter int         STAT_W    = 8,
   parameter logic [6:0] FIFO_ADDR = 7'h7F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              spi_cs_n,
   input logic              spi_miso,
   input logic              irq_n,
   input logic [STAT_W-1:0] evt_in,
   input logic [STAT_W-1:0] stat_q,
   input logic [STAT_W-1:0] clr_mask,
   input logic              wr_en,
   input logic              cs_act,
   input logic              byte_vld,
   input logic              byte_cmd,
   input logic [6:0]        addr_q,
   input logic              pop,
   input logic              fifo_empty
);

   AST_MISO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
         |-> (spi_miso == 1'b0)); // R8

   AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_in) |=> ((stat_q & $past(evt_in)) == $past(evt_in))); // R7

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && (clr_mask == '0) && !wr_en) |=> !irq_n); // R6

   AST_FIFO_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !byte_cmd && addr_q == FIFO_ADDR) |=> (addr_q == FIFO_ADDR)); // R4

   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !fifo_empty); // R4

   AST_WRITE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> cs_act); // R9

endmodule

bind spi_regfile_slave spi_rf_checker #(.STAT_W(STAT_W), .FIFO_ADDR(FIFO_ADDR)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .spi_cs_n  (spi_cs_n),
   .spi_miso  (spi_miso),
   .irq_n     (irq_n),
   .evt_in    (evt_in),
   .stat_q    (stat_q),
   .clr_mask  (clr_mask),
   .wr_en     (wr_en),
   .cs_act    (cs_act),
   .byte_vld  (byte_vld),
   .byte_cmd  (byte_cmd),
   .addr_q    (addr_q),
   .pop       (pop),
   .fifo_empty(fifo_empty)
);

// File: tb/spi_regfile_slave_tb.sv
`timescale 1ns/1ps
module spi_regfile_slave_tb;

   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_sck = 1'b0;
   logic       spi_cs_n = 1'b1;
   logic       spi_mosi = 1'b0;
   logic       spi_miso;
   logic       spi_miso_en;
   logic       irq_n;
   logic [7:0] evt_in = '0;
   logic       fifo_wr_en = 1'b0;
   logic [7:0] fifo_wr_data = '0;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   spi_regfile_slave u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_sck     (spi_sck),
      .spi_cs_n    (spi_cs_n),
      .spi_mosi    (spi_mosi),
      .spi_miso    (spi_miso),
      .spi_miso_en (spi_miso_en),
      .irq_n       (irq_n),
      .evt_in      (evt_in),
      .fifo_wr_en  (fifo_wr_en),
      .fifo_wr_data(fifo_wr_data)
   );

   // address (7 bits) and data (8 bits) written, then read back
   localparam logic [14:0] VEC [6] = '{
      {7'h10, 8'h5A}, {7'h11, 8'hA5}, {7'h30, 8'h3C},
      {7'h00, 8'h81}, {7'h7E, 8'hFF}, {7'h40, 8'h01}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic spi_bits(input logic [7:0] o, input int n, output logic [7:0] i);
      i = '0;
      for (int j = 7; j > 7 - n; j--) begin
         spi_mosi = o[j];
         tick(HALF);
         i[j] = spi_miso;
         spi_sck = 1'b1;
         tick(HALF);
         spi_sck = 1'b0;
      end
   endtask

   task automatic spi_begin;
      spi_cs_n = 1'b0;
      tick(HALF);
   endtask

   task automatic spi_end;
      tick(HALF);
      spi_cs_n = 1'b1;
      tick(8);
   endtask

   task automatic reg_write(input logic [6:0] a, input logic [7:0] d);
      logic [7:0] dummy;
      spi_begin();
      spi_bits({1'b1, a}, 8, dummy);
      spi_bits(d, 8, dummy);
      spi_end();
   endtask

   task automatic reg_read(input logic [6:0] a, input logic [7:0] filler, output logic [7:0] d);
      logic [7:0] dummy;
      spi_begin();
      spi_bits({1'b0, a}, 8, dummy);
      spi_bits(filler, 8, d);
      spi_end();
   endtask

   task automatic push_q(input logic [7:0] d);
      fifo_wr_data = d;
      fifo_wr_en   = 1'b1;
      tick(1);
      fifo_wr_en   = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [7:0] rd;
      logic [7:0] dummy;
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R10 reset state
      check("R10 irq_n after reset", {7'd0, irq_n}, 8'h01);
      check("R8 miso_en idle", {7'd0, spi_miso_en}, 8'h00);
      reg_read(7'h10, 8'h00, rd);
      check("R10 register after reset", rd, 8'h00);

      // R1 R2 vector table: single writes, then read back
      foreach (VEC[k]) reg_write(VEC[k][14:8], VEC[k][7:0]);
      foreach (VEC[k]) begin
         reg_read(VEC[k][14:8], 8'h00, rd);
         check("R1 R2 table readback", rd, VEC[k][7:0]);
      end

      // R3 burst write then burst read
      spi_begin();
      spi_bits(8'hA0, 8, dummy);
      spi_bits(8'hAA, 8, dummy);
      spi_bits(8'hBB, 8, dummy);
      spi_bits(8'hCC, 8, dummy);
      spi_bits(8'hDD, 8, dummy);
      spi_end();
      spi_begin();
      spi_bits(8'h20, 8, dummy);
      check("R8 miso_en while selected", {7'd0, spi_miso_en}, 8'h01);
      spi_bits(8'h00, 8, rd); check("R3 burst byte0", rd, 8'hAA);
      spi_bits(8'h00, 8, rd); check("R3 burst byte1", rd, 8'hBB);
      spi_bits(8'h00, 8, rd); check("R3 burst byte2", rd, 8'hCC);
      spi_bits(8'h00, 8, rd); check("R3 burst byte3", rd, 8'hDD);
      spi_end();

      // R2 data sent during a read is discarded
      reg_read(7'h21, 8'h5A, rd);
      check("R2 read value", rd, 8'hBB);
      reg_read(7'h21, 8'h00, rd);
      check("R2 read data ignored", rd, 8'hBB);

      // R9 abort mid-byte
      spi_begin();
      spi_bits(8'hB0, 8, dummy);
      spi_bits(8'hFF, 4, dummy);
      spi_end();
      reg_read(7'h30, 8'h00, rd);
      check("R9 partial byte discarded", rd, 8'h3C);

      // R5 status writes ignored
      reg_write(7'h03, 8'hFF);
      reg_read(7'h03, 8'h00, rd);
      check("R5 status write ignored", rd, 8'h00);

      // R5 R6 events, interrupt, read to clear
      reg_write(7'h04, 8'h04);
      evt_in = 8'h05; tick(1); evt_in = 8'h00; tick(2);
      check("R6 irq_n low on enabled event", {7'd0, irq_n}, 8'h00);
      tick(20);
      check("R6 irq_n stays low until read", {7'd0, irq_n}, 8'h00);
      reg_read(7'h03, 8'h00, rd);
      check("R5 status read value", rd, 8'h05);
      check("R6 irq_n released after read", {7'd0, irq_n}, 8'h01);
      reg_read(7'h03, 8'h00, rd);
      check("R5 status cleared by read", rd, 8'h00);

      // R7 event in the same cycle as the clearing read
      evt_in = 8'h01; tick(1); evt_in = 8'h00; tick(2);
      fork
         reg_read(7'h03, 8'h00, rd);
         begin
            tick(146);
            evt_in = 8'h01;
            tick(1);
            evt_in = 8'h00;
         end
      join
      check("R7 first status read", rd, 8'h01);
      reg_read(7'h03, 8'h00, rd);
      check("R7 coinciding event kept", rd, 8'h01);

      // R4 queue port
      reg_write(7'h7F, 8'h99);
      reg_read(7'h7F, 8'h00, rd);
      check("R4 write to queue discarded, empty read", rd, 8'h00);
      push_q(8'h11); push_q(8'h22); push_q(8'h33);
      spi_begin();
      spi_bits(8'h7F, 8, dummy);
      spi_bits(8'h00, 8, rd); check("R4 queue first", rd, 8'h11);
      spi_bits(8'h00, 8, rd); check("R4 queue second, no increment", rd, 8'h22);
      spi_end();
      spi_begin();
      spi_bits(8'h7F, 8, dummy);
      spi_bits(8'h00, 8, rd); check("R4 prefetched entry not lost", rd, 8'h33);
      spi_bits(8'h00, 8, rd); check("R4 empty queue returns zero", rd, 8'h00);
      spi_end();

      // R8 idle output
      check("R8 miso idle level", {7'd0, spi_miso}, 8'h00);
      check("R8 miso_en released", {7'd0, spi_miso_en}, 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule